// File: doc/BRIEF.md
# Multi-lane ADC Sample Serializer

This block turns 14-bit conversion results into a serial stream on one or two data lanes, together with a frame marker and a forwarded data-clock indicator. Words arrive on a valid/ready stream port. A one-word holding register buffers each word until the next frame boundary, where it is loaded into the shift stage. The bit clock is modelled as a single-cycle enable, `bit_en`, and exactly one bit per lane leaves on each enable.

Two static settings control the frame. The lane count is one or two. The serialization length is 12, 14 or 16 bits, counted across all lanes together.

- In two-lane mode the word is interleaved. The odd-indexed bits go on lane A and the even-indexed bits go on lane B, both most significant bit first.
- A 16-bit frame appends zeros after the data bits.
- A 12-bit frame drops the two least significant bits.
- Both settings are sampled only when a frame starts, so changing them mid-frame never corrupts a word already in flight.

Stream rules: `smp_ready` is high exactly when the holding register is empty. A word transfers on a clock edge where `smp_valid` and `smp_ready` are both high. After a transfer, `smp_ready` stays low until the next frame start empties the register, and that frame carries the word. If no word is held at a frame start, that frame carries all zeros. A producer must keep `smp_data` stable while `smp_valid` is high and `smp_ready` is low.

Top module: `adc_word_serializer`

## Requirements
- R1: While reset is asserted (`rst_n` low), `lane_a`, `lane_b`, `frame_out` and `dclk_out` are 0 and `smp_ready` is 1.
- R2: With one lane and the 14-bit length (`cfg_len`=1), one frame is 14 enables long. Lane A carries D13 down to D0, one bit per `bit_en`.
- R3: With the 16-bit length (`cfg_len`=2, and code 3 behaves the same), one-lane frames are D13..D0 followed by two 0 bits. Two-lane frames are 8 enables long, and each lane ends with one 0 bit.
- R4: With the 12-bit length (`cfg_len`=0), D1 and D0 are never sent. A one-lane frame is D13..D2 over 12 enables, and a two-lane frame is 6 enables long.
- R5: With two lanes (`cfg_two_lane`=1), lane A carries D13, D11, ... in that order and lane B carries D12, D10, ... in the same enables.
- R6: In one-lane mode `lane_b` stays at 0.
- R7: `frame_out` is 1 for the first ceil(N/2) enables of each frame and 0 for the rest, where N is the number of enables per frame. It rises in the enable that carries the most significant bit.
- R8: All four serial outputs change only in the cycle after a `bit_en` pulse, and `dclk_out` inverts on every `bit_en`.
- R9: `smp_ready` is 1 exactly when no word is held. A word accepted during one frame is sent in the next frame. A frame that starts with no word held sends all zeros.
- R10: `cfg_two_lane` and `cfg_len` are sampled only at the first enable of a frame. Changes made at other times have no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample word offered |
| smp_ready | output | 1 | Holding register empty, word will be taken |
| smp_data | input | 14 | Sample word, D13..D0 |
| bit_en | input | 1 | Bit-clock enable, one bit per lane per pulse |
| cfg_two_lane | input | 1 | 1 = two lanes, 0 = lane A only |
| cfg_len | input | 2 | Frame length: 0 = 12, 1 = 14, 2 or 3 = 16 bits |
| lane_a | output | 1 | Serial lane A |
| lane_b | output | 1 | Serial lane B |
| frame_out | output | 1 | Frame marker, high in the first half of each frame |
| dclk_out | output | 1 | Data-clock indicator, inverts per bit |

## Verification
The hardest situation to reach is a settings change that lands in the middle of a frame while a word is also waiting in the holding register. The settings must not take effect until the next frame start, and the waiting word must go out in that next frame. One section of the stimulus therefore changes `cfg_two_lane` and `cfg_len` to pseudo-random values every cycle, with words offered continuously. This puts settings changes at every offset within a frame and against every frame length, while the holding register stays occupied.

Other sections cover the following cases:
- `bit_en` high on every cycle, so that a word transfer and a frame start fall on the same clock edge.
- Producer pauses, so that frames start with no word held and send zeros.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
  localparam int unsigned DATA_W  = 14;
  localparam int unsigned FRAME_W = 16;

  typedef enum logic [1:0] {
    LEN_12 = 2'd0,
    LEN_14 = 2'd1,
    LEN_16 = 2'd2,
    LEN_16B = 2'd3
  } frame_len_e;

  function automatic int unsigned total_bits(input logic [1:0] code);
    case (code)
      LEN_12:  return 12;
      LEN_14:  return 14;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned lane_bits(input logic two, input logic [1:0] code);
    return two ? total_bits(code) / 2 : total_bits(code);
  endfunction
endpackage

// File: rtl/adc_ser_hold.sv
module adc_ser_hold #(
  parameter int unsigned DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_q;
  logic [DW-1:0] data_q;

  assign in_ready = ~full_q;
  assign full     = full_q;
  assign data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) full_q <= 1'b0;
      if (in_valid && ~full_q) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end
    end
  end
endmodule

// File: rtl/adc_ser_frame_ctr.sv
module adc_ser_frame_ctr #(
  parameter int unsigned KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic [KW-1:0] n_in,
  output logic          start,
  output logic [KW-1:0] k,
  output logic [KW-1:0] n_eff
);
  logic [KW-1:0] cnt_q;
  logic [KW-1:0] n_q;

  assign start = (cnt_q == '0);
  assign k     = cnt_q;
  assign n_eff = start ? n_in : n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      n_q   <= '0;
    end else if (bit_en) begin
      if (start) n_q <= n_in;
      if (cnt_q == n_eff - KW'(1)) cnt_q <= '0;
      else                         cnt_q <= cnt_q + KW'(1);
    end
  end
endmodule

// File: rtl/adc_ser_lane_pick.sv
module adc_ser_lane_pick #(
  parameter int unsigned FW = 16,
  parameter int unsigned KW = 5
) (
  input  logic [FW-1:0] word,
  input  logic [KW-1:0] k,
  input  logic          two,
  output logic [1:0]    bits
);
  localparam int unsigned IW = KW + 1;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [IW-1:0] idx;
    logic          avail;
    always_comb begin
      if (two) idx = IW'(FW - 1) - ({k, 1'b0} + IW'(l));
      else     idx = IW'(FW - 1) - {1'b0, k};
      avail = (l == 0) || two;
      if (avail && (idx < IW'(FW))) bits[l] = word[idx[$clog2(FW)-1:0]];
      else                         bits[l] = 1'b0;
    end
  end
endmodule

// File: rtl/adc_word_serializer.sv
module adc_word_serializer #(
  parameter int unsigned DW = adc_ser_pkg::DATA_W,
  parameter int unsigned FW = adc_ser_pkg::FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [DW-1:0] smp_data,
  input  logic          bit_en,
  input  logic          cfg_two_lane,
  input  logic [1:0]    cfg_len,
  output logic          lane_a,
  output logic          lane_b,
  output logic          frame_out,
  output logic          dclk_out
);
  localparam int unsigned KW  = $clog2(FW + 1);
  localparam int unsigned PAD = FW - DW;

  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          frm_start;
  logic [KW-1:0] k, n_in, n_eff, half;
  logic [FW-1:0] word_q, start_word, word_eff;
  logic          two_q, two_eff;
  logic [1:0]    pick;

  assign n_in = KW'(adc_ser_pkg::lane_bits(cfg_two_lane, cfg_len));

  adc_ser_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(smp_valid), .in_ready(smp_ready), .in_data(smp_data),
    .take(bit_en && frm_start), .full(hold_full), .data(hold_data)
  );

  adc_ser_frame_ctr #(.KW(KW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .n_in(n_in),
    .start(frm_start), .k(k), .n_eff(n_eff)
  );

  assign start_word = hold_full ? {hold_data, {PAD{1'b0}}} : '0;
  assign word_eff   = frm_start ? start_word : word_q;
  assign two_eff    = frm_start ? cfg_two_lane : two_q;
  assign half       = (n_eff + KW'(1)) >> 1;

  adc_ser_lane_pick #(.FW(FW), .KW(KW)) u_pick (
    .word(word_eff), .k(k), .two(two_eff), .bits(pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      two_q     <= 1'b0;
      lane_a    <= 1'b0;
      lane_b    <= 1'b0;
      frame_out <= 1'b0;
      dclk_out  <= 1'b0;
    end else if (bit_en) begin
      if (frm_start) begin
        word_q <= start_word;
        two_q  <= cfg_two_lane;
      end
      lane_a    <= pick[0];
      lane_b    <= pick[1];
      frame_out <= (k < half);
      dclk_out  <= ~dclk_out;
    end
  end
endmodule

// File: rtl/adc_word_serializer_chk.sv
module adc_word_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic smp_valid,
  input logic smp_ready,
  input logic cfg_two_lane,
  input logic frm_start,
  input logic lane_a,
  input logic lane_b,
  input logic frame_out,
  input logic dclk_out
);
  p_take_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready |=> !smp_ready);

  p_quiet_between_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(lane_a) && $stable(lane_b) && $stable(frame_out) && $stable(dclk_out));

  p_dclk_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> dclk_out != $past(dclk_out));

  p_frame_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && frm_start |=> frame_out);

  p_laneb_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && frm_start && !cfg_two_lane |=> !lane_b);
endmodule

bind adc_word_serializer adc_word_serializer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .cfg_two_lane(cfg_two_lane), .frm_start(frm_start),
  .lane_a(lane_a), .lane_b(lane_b), .frame_out(frame_out), .dclk_out(dclk_out)
);

// File: tb/adc_word_serializer_test.sv
module adc_word_serializer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [13:0] smp_data = '0;
  logic        bit_en = 1'b0;
  logic        cfg_two_lane = 1'b0;
  logic [1:0]  cfg_len = 2'd1;
  logic        lane_a, lane_b, frame_out, dclk_out;

  int total = 0;
  int bad = 0;
  string sect = "";
  bit [31:0] seed = 32'h1234_5678;
  bit acc_pend = 1'b0;

  adc_word_serializer uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .bit_en(bit_en), .cfg_two_lane(cfg_two_lane),
    .cfg_len(cfg_len), .lane_a(lane_a), .lane_b(lane_b),
    .frame_out(frame_out), .dclk_out(dclk_out)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference state
  int        m_cnt, m_n;
  bit        m_two;
  bit [1:0]  m_len;
  bit [15:0] m_word;
  bit        m_hv;
  bit [13:0] m_hd;
  bit        e_a, e_b, e_f, e_d;

  function automatic int lbits(bit two, bit [1:0] c);
    int tot;
    tot = (c == 0) ? 12 : (c == 1) ? 14 : 16;
    return two ? tot / 2 : tot;
  endfunction

  always @(posedge clk) begin
    bit acc;
    int k;
    if (!rst_n) begin
      m_cnt = 0; m_n = 0; m_two = 0; m_len = 0; m_word = 0;
      m_hv = 0; m_hd = 0; e_a = 0; e_b = 0; e_f = 0; e_d = 0;
    end else begin
      acc = smp_valid && !m_hv;
      if (bit_en) begin
        if (m_cnt == 0) begin
          m_two  = cfg_two_lane;
          m_len  = cfg_len;
          m_n    = lbits(cfg_two_lane, cfg_len);
          m_word = m_hv ? {m_hd, 2'b00} : 16'h0;
          m_hv   = 0;
        end
        k = m_cnt;
        if (m_two) begin
          e_a = m_word[15 - 2*k];
          e_b = m_word[14 - 2*k];
        end else begin
          e_a = m_word[15 - k];
          e_b = 1'b0;
        end
        e_f = (k < (m_n + 1) / 2);
        e_d = ~e_d;
        m_cnt = (k == m_n - 1) ? 0 : k + 1;
      end
      if (acc) begin
        m_hv = 1;
        m_hd = smp_data;
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string ta, tb;
    if (sect != "") begin
      ta = sect; tb = sect;
    end else begin
      ta = (m_len >= 2) ? "R3" : (m_len == 0) ? "R4" : m_two ? "R5" : "R2";
      tb = m_two ? "R5" : "R6";
    end
    chk(ta, "lane_a", lane_a, e_a);
    chk(tb, "lane_b", lane_b, e_b);
    chk((sect != "") ? sect : "R7", "frame_out", frame_out, e_f);
    chk((sect != "") ? sect : "R8", "dclk_out", dclk_out, e_d);
    chk((sect != "") ? sect : "R9", "smp_ready", smp_ready, !m_hv);
  endtask

  task automatic run(input int n, input int div, input bit offer,
                     input bit two, input bit [1:0] len, input bit wobble);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      seed = seed * 32'd1103515245 + 32'd12345;
      if (!smp_valid || acc_pend) begin
        smp_valid = offer;
        if (offer) smp_data = seed[29:16];
      end
      bit_en = ((i % div) == 0);
      if (wobble) begin
        cfg_two_lane = seed[7];
        cfg_len      = seed[9:8];
      end else begin
        cfg_two_lane = two;
        cfg_len      = len;
      end
      acc_pend = smp_valid && smp_ready;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "lane_a rst", lane_a, 0);
    chk("R1", "lane_b rst", lane_b, 0);
    chk("R1", "frame_out rst", frame_out, 0);
    chk("R1", "dclk_out rst", dclk_out, 0);
    chk("R1", "smp_ready rst", smp_ready, 1);
    rst_n = 1'b1;
    for (int t = 0; t < 2; t++)
      for (int l = 0; l < 4; l++)
        run(120, 2, 1'b1, t[0], l[1:0], 1'b0);
    sect = "R9";
    run(100, 1, 1'b1, 1'b1, 2'd2, 1'b0);
    run(100, 3, 1'b0, 1'b0, 2'd1, 1'b0);
    run(100, 1, 1'b1, 1'b0, 2'd0, 1'b0);
    sect = "R10";
    run(400, 2, 1'b1, 1'b0, 2'd0, 1'b1);
    run(300, 1, 1'b1, 1'b0, 2'd0, 1'b1);
    sect = "";
    run(60, 1, 1'b0, 1'b1, 2'd1, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule